// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the fetch program counter and the fetch-to-decode pipeline register of a 32-bit core. It decides, while an instruction sits in decode, where fetch goes next. Two conditional branches are supported: one is taken when its two register operands are equal, and the other is taken when they differ. Two unconditional jumps are also supported: a plain jump and a jump that also produces a return address. Branches are resolved in the decode stage, so a taken branch or any jump costs exactly one fetched instruction. That instruction is squashed by loading an all-zero word, which the core treats as a no-op.

The surrounding core supplies three things. The first is the word returned by instruction memory for the current fetch PC. The second and third are the two register values that belong to the instruction now in decode. Both the fetch PC and the decode register are held while the stall input is high.

A branch offset counts 32-bit words from the instruction that follows the branch. A jump keeps the top four bits of that sequential address and takes the remaining address bits from its 26-bit word index.

Top module: `pc_redirect_unit`

## Requirements
- R1: While reset is low, and after it is released, the fetch PC is 0x00400000 and the decode word is all zeros. With the all-zero word in decode, `redirect` is low.
- R2: A branch target is the decode PC plus 4 plus the sign-extended 16-bit immediate (instruction bits [15:0]) times 4. An immediate of 0 lands on the next instruction, and an immediate of 0xFFFF lands on the branch itself.
- R3: Opcode 4 (instruction bits [31:26]) is taken exactly when `src_a` equals `src_b`.
- R4: Opcode 5 is taken exactly when `src_a` differs from `src_b`.
- R5: The branch reach covers the immediate extremes 0x7FFF (+32767 words) and 0x8000 (-32768 words).
- R6: Opcodes 2 and 3 are always taken. Their target is {(decode PC+4)[31:28], instruction bits [25:0], 2'b00}.
- R7: For opcode 3, `link_en` is 1, `link_addr` equals the decode PC plus 8, and `link_reg` is 31. For every other instruction, `link_en` is 0.
- R8: When the decode instruction is not taken, or its opcode is none of 2, 3, 4 and 5, `next_pc` is the fetch PC plus 4 and `redirect` is low. At the next edge, the fetched word enters decode unchanged.
- R9: When `redirect` is high, `next_pc` is the target. At the next unstalled edge, the fetch PC becomes that target and the decode word becomes all zeros.
- R10: While `stall` is high, a clock edge leaves the fetch PC, the decode word and the decode PC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Holds the fetch PC and the decode register |
| fetch_word | input | 32 | Instruction word read at `fetch_pc` |
| src_a | input | 32 | First register operand of the decode instruction |
| src_b | input | 32 | Second register operand of the decode instruction |
| fetch_pc | output | 32 | Current fetch address |
| dec_word | output | 32 | Instruction held in decode |
| dec_pc | output | 32 | Address of the decode instruction |
| next_pc | output | 32 | Fetch address for the next cycle |
| redirect | output | 1 | Decode instruction is taken |
| squash | output | 1 | Request to replace the fetched word with a no-op |
| link_en | output | 1 | Decode instruction writes a return address |
| link_addr | output | 32 | Return address value |
| link_reg | output | 5 | Register index that receives the return address |

## Verification
The bench targets the off-by-one cases in branch arithmetic.

- An immediate of 0 must fall through, and an immediate of -1 must land on the branch itself. A design that offsets from the branch's own address, rather than the following one, misses both by four bytes.
- The extreme immediates 0x7FFF and 0x8000 are applied. A zero-extended or unscaled immediate sends the second far forward or only a few bytes away.
- A jump is issued from the last word below a 256 MiB boundary, so its region bits must come from PC+4. A design that takes them from the decode PC keeps the old region.

The bench also checks the pipeline side:

- A taken redirect must leave an all-zero word in decode. If the squash is missing, the wrong-path instruction survives.
- A stalled edge must leave everything held, which catches a stall that still advances the PC.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int XLEN    = 32;
  localparam int OP_W    = 6;
  localparam int IMM_W   = 16;
  localparam int IDX_W   = 26;
  localparam int REG_W   = 5;
  localparam int INSN_B  = 4;
  localparam int SHIFT_W = 2;
  localparam int REGION_W = XLEN - IDX_W - SHIFT_W;

  localparam logic [OP_W-1:0] OPC_JMP  = 6'd2;
  localparam logic [OP_W-1:0] OPC_JAL  = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OP_W-1:0] OPC_BNE  = 6'd5;

  // Sign-extend a word offset and turn it into a byte offset.
  function automatic logic [XLEN-1:0] word_offset(input logic [IMM_W-1:0] imm);
    return {{(XLEN-IMM_W-SHIFT_W){imm[IMM_W-1]}}, imm, {SHIFT_W{1'b0}}};
  endfunction

  // Keep the region bits of the sequential address, splice in the word index.
  function automatic logic [XLEN-1:0] region_splice(input logic [XLEN-1:0] seq,
                                                    input logic [IDX_W-1:0] idx);
    return {seq[XLEN-1 -: REGION_W], idx, {SHIFT_W{1'b0}}};
  endfunction
endpackage

// File: rtl/pcu_targets.sv
module pcu_targets
  import pcu_pkg::*;
(
  input  logic [XLEN-1:0]  dec_pc,
  input  logic [IDX_W-1:0] field,
  output logic [XLEN-1:0]  br_tgt,
  output logic [XLEN-1:0]  jmp_tgt,
  output logic [XLEN-1:0]  ret_addr
);
  logic [XLEN-1:0] seq_pc;

  always_comb begin
    seq_pc   = dec_pc + XLEN'(INSN_B);
    br_tgt   = seq_pc + word_offset(field[IMM_W-1:0]);
    jmp_tgt  = region_splice(seq_pc, field);
    ret_addr = seq_pc + XLEN'(INSN_B);
  end
endmodule

// File: rtl/pcu_decide.sv
module pcu_decide
  import pcu_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  output logic [XLEN-1:0] next_pc,
  output logic            redirect,
  output logic            is_call
);
  logic is_beq, is_bne, is_jmp, same, br_take;

  always_comb begin
    is_beq  = (opcode == OPC_BEQ);
    is_bne  = (opcode == OPC_BNE);
    is_call = (opcode == OPC_JAL);
    is_jmp  = (opcode == OPC_JMP) || is_call;
    same    = (src_a == src_b);
    br_take = (is_beq && same) || (is_bne && !same);
    redirect = br_take || is_jmp;
    if (is_jmp)       next_pc = jmp_tgt;
    else if (br_take) next_pc = br_tgt;
    else              next_pc = fetch_pc + XLEN'(INSN_B);
  end
endmodule

// File: rtl/pcu_pipe_regs.sv
module pcu_pipe_regs
  import pcu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            redirect,
  input  logic [XLEN-1:0] next_pc,
  input  logic [XLEN-1:0] fetch_word,
  output logic [XLEN-1:0] fetch_pc,
  output logic [XLEN-1:0] dec_word,
  output logic [XLEN-1:0] dec_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      dec_word <= '0;
      dec_pc   <= '0;
    end else if (!stall) begin
      fetch_pc <= next_pc;
      dec_pc   <= fetch_pc;
      dec_word <= redirect ? '0 : fetch_word;
    end
  end
endmodule

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit
  import pcu_pkg::*;
#(
  parameter logic [XLEN-1:0]  RESET_PC = 32'h0040_0000,
  parameter logic [REG_W-1:0] LINK_IDX = 5'd31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic [XLEN-1:0]  fetch_word,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  output logic [XLEN-1:0]  fetch_pc,
  output logic [XLEN-1:0]  dec_word,
  output logic [XLEN-1:0]  dec_pc,
  output logic [XLEN-1:0]  next_pc,
  output logic             redirect,
  output logic             squash,
  output logic             link_en,
  output logic [XLEN-1:0]  link_addr,
  output logic [REG_W-1:0] link_reg
);
  logic [XLEN-1:0] br_tgt_w, jmp_tgt_w;

  pcu_pipe_regs #(.RESET_PC(RESET_PC)) u_regs (
    .clk(clk), .rst_n(rst_n), .stall(stall), .redirect(redirect),
    .next_pc(next_pc), .fetch_word(fetch_word),
    .fetch_pc(fetch_pc), .dec_word(dec_word), .dec_pc(dec_pc)
  );

  pcu_targets u_tgt (
    .dec_pc(dec_pc), .field(dec_word[IDX_W-1:0]),
    .br_tgt(br_tgt_w), .jmp_tgt(jmp_tgt_w), .ret_addr(link_addr)
  );

  pcu_decide u_dec (
    .opcode(dec_word[XLEN-1 -: OP_W]), .src_a(src_a), .src_b(src_b),
    .fetch_pc(fetch_pc), .br_tgt(br_tgt_w), .jmp_tgt(jmp_tgt_w),
    .next_pc(next_pc), .redirect(redirect), .is_call(link_en)
  );

  assign squash   = redirect;
  assign link_reg = LINK_IDX;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fetch_pc == $past(fetch_pc)) && (dec_word == $past(dec_word)));

  assert_squash_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !stall) |=> (dec_word == '0));

  assert_seq_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && !stall) |=> (fetch_pc == $past(fetch_pc) + XLEN'(INSN_B)));

  assert_decode_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (dec_pc == $past(fetch_pc)));

  assert_call_redirects_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_en |-> redirect);
endmodule

// File: tb/pc_redirect_unit_test.sv
module pc_redirect_unit_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 11;
  localparam logic [31:0] FILL = 32'h0022_1820;

  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  logic [31:0] fetch_word = FILL, src_a = '0, src_b = '0;
  logic [31:0] fetch_pc, dec_word, dec_pc, next_pc, link_addr;
  logic redirect, squash, link_en;
  logic [4:0] link_reg;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_redirect_unit uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_word(fetch_word),
    .src_a(src_a), .src_b(src_b), .fetch_pc(fetch_pc), .dec_word(dec_word),
    .dec_pc(dec_pc), .next_pc(next_pc), .redirect(redirect), .squash(squash),
    .link_en(link_en), .link_addr(link_addr), .link_reg(link_reg)
  );

  // Each vector is loaded into decode from fetch PC 0x00400000 right after reset.
  localparam logic [31:0] V_INS [NV] = '{
    32'h1022_0000, 32'h1022_FFFF, 32'h1022_0005, 32'h1422_0003, 32'h1422_0003,
    32'h1022_7FFF, 32'h1022_8000, 32'h0812_3456, 32'h0FFF_FFFF, 32'h0022_1820,
    32'h1822_0004};
  localparam logic [31:0] V_A [NV] = '{5, 5, 5, 5, 7, 9, 9, 0, 0, 5, 5};
  localparam logic [31:0] V_B [NV] = '{5, 5, 6, 6, 7, 9, 9, 1, 2, 5, 5};
  localparam logic [31:0] V_NPC [NV] = '{
    32'h0040_0004, 32'h0040_0000, 32'h0040_0008, 32'h0040_0010, 32'h0040_0008,
    32'h0042_0000, 32'h003E_0004, 32'h0048_D158, 32'h0FFF_FFFC, 32'h0040_0008,
    32'h0040_0008};
  localparam bit V_TAKE [NV] = '{1, 1, 0, 1, 0, 1, 1, 1, 1, 0, 0};
  localparam bit V_LINK [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam string V_TAG [NV] = '{"R2", "R2", "R3", "R4", "R4", "R5", "R5",
                                   "R6", "R7", "R8", "R8"};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stall = 1'b0; fetch_word = FILL;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1 fetch_pc", fetch_pc, 32'h0040_0000);
    check("R1 dec_word", dec_word, 32'h0);
    check("R1 redirect", {31'b0, redirect}, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      fetch_word = V_INS[i]; src_a = V_A[i]; src_b = V_B[i];
      @(posedge clk); @(negedge clk);
      fetch_word = FILL;
      check({V_TAG[i], " redirect"}, {31'b0, redirect}, {31'b0, V_TAKE[i]});
      check({V_TAG[i], " squash"}, {31'b0, squash}, {31'b0, V_TAKE[i]});
      check({V_TAG[i], " next_pc"}, next_pc, V_NPC[i]);
      check("R7 link_en", {31'b0, link_en}, {31'b0, V_LINK[i]});
      if (V_LINK[i]) begin
        check("R7 link_addr", link_addr, 32'h0040_0008);
        check("R7 link_reg", {27'b0, link_reg}, 32'd31);
      end
      @(posedge clk); @(negedge clk);
      check(V_TAKE[i] ? "R9 fetch_pc" : "R8 fetch_pc", fetch_pc, V_NPC[i]);
      check(V_TAKE[i] ? "R9 dec_word" : "R8 dec_word", dec_word,
            V_TAKE[i] ? 32'h0 : FILL);
    end

    // R6: jump from the last word below a region boundary
    do_reset();
    fetch_word = 32'h0BFF_FFFF;              // jump to 0x0FFFFFFC
    @(posedge clk); @(negedge clk);
    fetch_word = FILL;
    @(posedge clk); @(negedge clk);
    check("R9 jump lands", fetch_pc, 32'h0FFF_FFFC);
    fetch_word = 32'h0800_0000;              // jump, index 0
    @(posedge clk); @(negedge clk);
    check("R6 dec_pc", dec_pc, 32'h0FFF_FFFC);
    check("R6 region from PC+4", next_pc, 32'h1000_0000);

    // R10: stall holds state with a taken branch in decode
    do_reset();
    fetch_word = 32'h1022_0000; src_a = 3; src_b = 3;
    @(posedge clk); @(negedge clk);
    stall = 1'b1; fetch_word = FILL;
    @(posedge clk); @(negedge clk);
    check("R10 fetch_pc", fetch_pc, 32'h0040_0004);
    check("R10 dec_word", dec_word, 32'h1022_0000);
    check("R10 dec_pc", dec_pc, 32'h0040_0000);
    stall = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 after stall", fetch_pc, 32'h0040_0004);
    check("R9 squash after stall", dec_word, 32'h0);

    finish_run();
  end
endmodule